// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block tracks which virtual pages sit in a small set of physical page frames and picks a frame to reuse when a page that is not resident is requested. It uses the second-chance ("clock") policy. Each page has a referenced flag. A rotating hand walks the frames. Frames whose page was referenced lose their flag and are passed over once. The first frame holding an unreferenced page becomes the victim.

A requester presents a page number with `reqValid` while `busy` is low.

- **Hit:** the page's referenced flag is set and the response appears one cycle later.
- **Miss:** the engine raises `busy` and examines one frame per cycle until it settles on a frame. It installs the page there and reports the frame and any page that was pushed out.

Data movement and backing storage are handled elsewhere. The engine only keeps the bookkeeping of the mapping.

Top module: `clock_repl`

## Requirements
- R1: After synchronous reset `busy` and `done` are low, every frame is empty, every referenced flag is clear, and the hand sits just before frame 0, so the first miss lands in frame 0 (frames are numbered 0 to NUM_FRAMES-1 on `rspFrame`) with `rspEvictValid` low.
- R2: A request accepted for a resident page never raises `busy`. It pulses `done` on the next cycle with `rspHit`=1, `rspFrame` = the frame holding the page, and `rspEvictValid`=0.
- R3: While empty frames remain, a miss fills the frame after the hand, taking frames in increasing order. It keeps `busy` high for exactly one cycle and reports `rspEvictValid`=0.
- R4: Every access sets the referenced flag of the requested page, on a hit as well as on a miss, so that page is skipped once by the next sweep.
- R5: A victim search starts at the frame after the hand. A frame whose page has its flag set has the flag cleared and is passed over. Moving past frame NUM_FRAMES-1 wraps to frame 0.
- R6: The first frame holding an unreferenced page is the victim. Its page is reported on `rspEvictPage` with `rspEvictValid`=1, and that page is no longer resident, so its next access misses.
- R7: After a replacement the new page is resident in the victim frame with its flag set, and the hand rests on that frame for the next search.
- R8: A search evaluates one frame per cycle. `busy` stays high for at most NUM_FRAMES+1 consecutive cycles.
- R9: `reqValid` is ignored while `busy` is high. A page offered then does not become resident.
- R10: With 3 frames and pages accessed in the order 1,2,3,1,4,2,1,5, the resulting placements are page 4 in frame 0 evicting page 1, page 1 in frame 2 evicting page 3, and page 5 in frame 1 evicting page 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request, taken when `busy` is low |
| reqPage | input | PAGE_W | Page number of the access |
| busy | output | 1 | Victim search in progress |
| done | output | 1 | One-cycle pulse: response fields are valid |
| rspHit | output | 1 | Page was already resident |
| rspFrame | output | FRAME_W | Frame now holding the page |
| rspEvictValid | output | 1 | A resident page was displaced |
| rspEvictPage | output | PAGE_W | Page that was displaced |

## Verification
A corrupted referenced flag or a misplaced hand does not show on the access that causes it. It shows on a later miss, either as a different victim frame and evicted page or as a `busy` window of the wrong length.

The bench therefore predicts, per miss, both the victim and the exact number of search cycles. A lost eviction marking shows as a false hit on the next access to the displaced page.

An accepted request during `busy` would show up later as a page that hits without ever having been loaded.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } clockState_t;

  typedef struct packed {
    logic takeHit;     // resident page accepted
    logic takeMiss;    // non-resident page accepted, start sweep
    logic sweepClear;  // frame under the candidate is passed over
    logic sweepLoad;   // candidate frame becomes the victim
  } clockStrobe_t;

endpackage

// File: rtl/clock_repl_ctrl.sv
module clock_repl_ctrl
  import clock_repl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         lookupHit,
  input  logic         candTaken,
  output clockStrobe_t strb,
  output logic         busy,
  output logic         done
);

  clockState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (lookupHit) begin
            strb.takeHit = 1'b1;
          end else begin
            strb.takeMiss = 1'b1;
            stateNext     = ST_SEARCH;
          end
        end
      end
      ST_SEARCH: begin
        if (candTaken) begin
          strb.sweepClear = 1'b1;
        end else begin
          strb.sweepLoad = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.takeHit | strb.sweepLoad;
    end
  end

  assign busy = (state == ST_SEARCH);

endmodule

// File: rtl/clock_repl_dp.sv
module clock_repl_dp
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int NUM_PAGES  = 8,
  parameter int FRAME_W    = $clog2(NUM_FRAMES),
  parameter int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst,
  input  clockStrobe_t       strb,
  input  logic [PAGE_W-1:0]  reqPage,
  output logic               lookupHit,
  output logic               candTaken,
  output logic               rspHit,
  output logic [FRAME_W-1:0] rspFrame,
  output logic               rspEvictValid,
  output logic [PAGE_W-1:0]  rspEvictPage
);

  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  // frame-side state
  logic [PAGE_W-1:0]     framePage [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] frameFull;
  // page-side state
  logic [FRAME_W-1:0]    pageFrame [NUM_PAGES];
  logic [NUM_PAGES-1:0]  pageRes;
  logic [NUM_PAGES-1:0]  pageRef;

  logic [FRAME_W-1:0] hand;
  logic [FRAME_W-1:0] candFrame;
  logic [PAGE_W-1:0]  candPage;
  logic [PAGE_W-1:0]  pendPage;

  assign candFrame = (hand == LAST_FRAME) ? '0 : hand + 1'b1;
  assign candPage  = framePage[candFrame];
  assign candTaken = frameFull[candFrame] & pageRef[candPage];
  assign lookupHit = pageRes[reqPage];

  always_ff @(posedge clk) begin
    if (rst) begin
      hand          <= LAST_FRAME;
      frameFull     <= '0;
      pageRes       <= '0;
      pageRef       <= '0;
      pendPage      <= '0;
      rspHit        <= 1'b0;
      rspFrame      <= '0;
      rspEvictValid <= 1'b0;
      rspEvictPage  <= '0;
      for (int f = 0; f < NUM_FRAMES; f++) framePage[f] <= '0;
      for (int p = 0; p < NUM_PAGES; p++)  pageFrame[p] <= '0;
    end else begin
      if (strb.takeHit) begin
        pageRef[reqPage] <= 1'b1;
        rspHit           <= 1'b1;
        rspFrame         <= pageFrame[reqPage];
        rspEvictValid    <= 1'b0;
        rspEvictPage     <= '0;
      end
      if (strb.takeMiss) begin
        pendPage <= reqPage;
      end
      if (strb.sweepClear) begin
        pageRef[candPage] <= 1'b0;
        hand              <= candFrame;
      end
      if (strb.sweepLoad) begin
        if (frameFull[candFrame]) begin
          pageRes[candPage] <= 1'b0;
          rspEvictValid     <= 1'b1;
          rspEvictPage      <= candPage;
        end else begin
          rspEvictValid <= 1'b0;
          rspEvictPage  <= '0;
        end
        framePage[candFrame] <= pendPage;
        frameFull[candFrame] <= 1'b1;
        pageRes[pendPage]    <= 1'b1;
        pageRef[pendPage]    <= 1'b1;
        pageFrame[pendPage]  <= candFrame;
        hand                 <= candFrame;
        rspHit               <= 1'b0;
        rspFrame             <= candFrame;
      end
    end
  end

endmodule

// File: rtl/clock_repl.sv
module clock_repl
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int NUM_PAGES  = 8,
  parameter int FRAME_W    = $clog2(NUM_FRAMES),
  parameter int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [PAGE_W-1:0]  reqPage,
  output logic               busy,
  output logic               done,
  output logic               rspHit,
  output logic [FRAME_W-1:0] rspFrame,
  output logic               rspEvictValid,
  output logic [PAGE_W-1:0]  rspEvictPage
);

  clockStrobe_t strb;
  logic lookupHit;
  logic candTaken;

  clock_repl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .lookupHit(lookupHit),
    .candTaken(candTaken),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  clock_repl_dp #(
    .NUM_FRAMES(NUM_FRAMES),
    .NUM_PAGES (NUM_PAGES),
    .FRAME_W   (FRAME_W),
    .PAGE_W    (PAGE_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .reqPage      (reqPage),
    .lookupHit    (lookupHit),
    .candTaken    (candTaken),
    .rspHit       (rspHit),
    .rspFrame     (rspFrame),
    .rspEvictValid(rspEvictValid),
    .rspEvictPage (rspEvictPage)
  );

endmodule

// File: rtl/clock_repl_checker.sv
module clock_repl_checker #(
  parameter int NUM_FRAMES = 3,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic               busy,
  input logic               done,
  input logic               rspHit,
  input logic [FRAME_W-1:0] rspFrame,
  input logic               rspEvictValid
);

  localparam int RUN_W = $clog2(NUM_FRAMES + 3) + 1;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R8: search window bounded
  assert_search_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busyRun <= RUN_W'(NUM_FRAMES + 1));

  // R9: a search only starts from an accepted request
  assert_busy_from_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reqValid));

  // R2: a hit response follows a request taken while idle
  assert_hit_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    (done && rspHit) |-> $past(reqValid && !busy));

  // R2: a hit never displaces a page
  assert_hit_no_evict_R2: assert property (@(posedge clk) disable iff (rst)
    (done && rspHit) |-> !rspEvictValid);

  // R7: a completed response is never reported while a search runs
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5: reported frame lies inside the frame range
  assert_frame_range_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (rspFrame <= FRAME_W'(NUM_FRAMES - 1)));

endmodule

bind clock_repl clock_repl_checker #(
  .NUM_FRAMES(NUM_FRAMES),
  .FRAME_W   (FRAME_W)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .reqValid     (reqValid),
  .busy         (busy),
  .done         (done),
  .rspHit       (rspHit),
  .rspFrame     (rspFrame),
  .rspEvictValid(rspEvictValid)
);

// File: tb/clock_repl_bench.sv
module clock_repl_bench;

  localparam int NF = 3;
  localparam int NP = 8;
  localparam int FW = $clog2(NF);
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic [PW-1:0] reqPage = '0;
  logic          busy, done, rspHit, rspEvictValid;
  logic [FW-1:0] rspFrame;
  logic [PW-1:0] rspEvictPage;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  typedef struct {
    int    hit;
    int    frame;
    int    ev;
    int    evPage;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  clock_repl #(.NUM_FRAMES(NF), .NUM_PAGES(NP)) u_clock_repl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqPage(reqPage),
    .busy(busy), .done(done), .rspHit(rspHit), .rspFrame(rspFrame),
    .rspEvictValid(rspEvictValid), .rspEvictPage(rspEvictPage)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses as done pulses appear
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        check(0, "R2 unexpected response", "done", "none");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspHit == e.hit[0] && rspFrame == FW'(e.frame) &&
              rspEvictValid == e.ev[0] &&
              (!e.ev[0] || rspEvictPage == PW'(e.evPage)), e.tag,
              $sformatf("hit=%0d frame=%0d ev=%0d evp=%0d", rspHit, rspFrame, rspEvictValid, rspEvictPage),
              $sformatf("hit=%0d frame=%0d ev=%0d evp=%0d", e.hit, e.frame, e.ev, e.evPage));
      end
    end
  end

  // driver: one access; intruder >= 0 is offered while busy
  task automatic access(input int pg, input int hit, input int frame, input int ev,
                        input int evPage, input int expBusy, input int intruder,
                        input string tag);
    int n;
    expItem_t e;
    e.hit = hit; e.frame = frame; e.ev = ev; e.evPage = evPage; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1;
    reqPage  = PW'(pg);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (busy) begin
      if (intruder >= 0) begin
        reqValid = 1'b1;
        reqPage  = PW'(intruder);
      end
      n++;
      @(negedge clk);
      reqValid = 1'b0;
    end
    check(n == expBusy, {tag, " busy cycles R8"}, $sformatf("%0d", n), $sformatf("%0d", expBusy));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset outputs",
          $sformatf("busy=%0d done=%0d", busy, done), "busy=0 done=0");

    // R10 sequence; R1 first fill in frame 0; R3 ordered fills
    access(1, 0, 0, 0, 0, 1, -1, "R1 R3 fill page1");
    access(2, 0, 1, 0, 0, 1, -1, "R3 fill page2");
    access(3, 0, 2, 0, 0, 1, -1, "R3 fill page3");
    access(1, 1, 0, 0, 0, 0, -1, "R2 hit page1");
    access(4, 0, 0, 1, 1, NF + 1, -1, "R5 R10 page4 full sweep");
    access(2, 1, 1, 0, 0, 0, -1, "R2 R4 hit page2");
    access(1, 0, 2, 1, 3, 2, -1, "R6 R10 page1 evicted earlier");
    access(5, 0, 1, 1, 2, 2, -1, "R7 R10 page5");

    // R4: hits re-arm all flags, next miss sweeps a full lap
    access(4, 1, 0, 0, 0, 0, -1, "R2 hit page4");
    access(1, 1, 2, 0, 0, 0, -1, "R2 hit page1");
    access(5, 1, 1, 0, 0, 0, -1, "R2 hit page5");
    access(6, 0, 2, 1, 1, NF + 1, 3, "R4 R8 R9 page6 wrap sweep");
    access(3, 0, 0, 1, 4, 1, -1, "R9 ignored page3 still misses");
    access(1, 0, 1, 1, 5, 1, -1, "R6 page1 absent after eviction");
    access(1, 1, 1, 0, 0, 0, -1, "R7 page1 resident after load");

    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && done == 1'b0, "R1 reset outputs again",
          $sformatf("busy=%0d done=%0d", busy, done), "busy=0 done=0");
    access(7, 0, 0, 0, 0, 1, -1, "R1 first miss after reset");
    access(1, 0, 1, 0, 0, 1, -1, "R1 R6 page1 cleared by reset");
    access(7, 1, 0, 0, 0, 0, -1, "R2 hit page7");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses seen", $sformatf("%0d", expQ.size()), "0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule